// File: doc/BRIEF.md
# Dual-Port Mailbox RAM

This block is a synchronous shared memory of 2048 bytes with two fully independent access sides, called left and right. Each side has an active-low select, an active-low output gate, a read/write select (high means read), an 11-bit address, an 8-bit write bus and an 8-bit read bus. Both sides can reach every location. A read is captured on the clock edge and shows on the read bus one cycle later. Each side also has a `rdrive` flag. When that flag is low, the read bus is held at zero, and the pad tristate is built from this flag.

The two highest locations double as doorbells between the sides. When the left side writes location 0x7FF, the right interrupt (`r_int_n`, active low) is raised. When the right side reads 0x7FF with its output gate open, the right interrupt is cleared. Location 0x7FE does the same in the opposite direction. Both doorbell locations still hold their data, so the side receiving a doorbell reads the message byte in the same access that clears its interrupt.

Each side has an active-low hold input, `busy_n`. While it is low, that side's writes are dropped, and any flag change its access would cause is frozen. Every side accepts one access per cycle. There is no back-pressure and no valid/ready handshake: a selected access always completes.

Top module: `dpr_mailbox_ram`

## Requirements
- R1: Every one of the 2048 locations can be written from one side and read back from the other side.
- R2: With `ce_n` high, a side performs no write and its `rdrive` is low, and its read bus is 0, in the following cycle.
- R3: With `ce_n` low, `rw` low and `busy_n` high, the write byte is stored at the address. With `busy_n` low, nothing is stored.
- R4: With `ce_n` low and `rw` high, the addressed byte appears on the read bus with `rdrive` high in the next cycle, but only if `oe_n` was low. If `oe_n` was high, `rdrive` stays low.
- R5: A left write to 0x7FF with `l_busy_n` high drives `r_int_n` low in the next cycle.
- R6: A right read of 0x7FF with `r_ce_n` and `r_oe_n` both low and `r_busy_n` high drives `r_int_n` high in the next cycle. The same read with `r_oe_n` high leaves the flag unchanged.
- R7: A right write to 0x7FE sets the left flag (`l_int_n` goes low). A left read of 0x7FE with the output gate open clears it. The same `busy_n` rules apply as in R5 and R6.
- R8: When the acting side's `busy_n` is low, a doorbell access leaves the flag it targets unchanged.
- R9: A synchronous active-high `rst` sets both `int_n` outputs high and both `rdrive` outputs low.
- R10: A doorbell write stores its byte, and the clearing read returns that byte.
- R11: If one side writes an address and the other side reads the same address in the same cycle, the read returns the old byte.
- R12: If a doorbell set and its clear fall in the same cycle, the set wins and the flag is raised.
- R13: If both sides write the same address in the same cycle, the left byte is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| l_ce_n | input | 1 | Left select, active low |
| l_oe_n | input | 1 | Left output gate, active low |
| l_rw | input | 1 | Left read (1) / write (0) |
| l_busy_n | input | 1 | Left hold, active low |
| l_addr | input | 11 | Left address |
| l_wdata | input | 8 | Left write byte |
| l_rdata | output | 8 | Left read byte (0 when not driving) |
| l_rdrive | output | 1 | Left read bus is being driven |
| l_int_n | output | 1 | Left interrupt, active low |
| r_ce_n | input | 1 | Right select, active low |
| r_oe_n | input | 1 | Right output gate, active low |
| r_rw | input | 1 | Right read (1) / write (0) |
| r_busy_n | input | 1 | Right hold, active low |
| r_addr | input | 11 | Right address |
| r_wdata | input | 8 | Right write byte |
| r_rdata | output | 8 | Right read byte (0 when not driving) |
| r_rdrive | output | 1 | Right read bus is being driven |
| r_int_n | output | 1 | Right interrupt, active low |

## Verification
The flag properties assume that every control input is a known 0 or 1 at each sampled edge. They also assume that a set and a clear of the same flag are only checked separately when they do not fall in the same cycle, which is why the clear property excludes a simultaneous set. The stimulus changes all inputs half a cycle away from the sampling edge and never leaves a control pin undriven. The bench exercises the same-cycle set/clear case on purpose and checks it against the set-wins rule.

// File: rtl/dpr_pkg.sv
package dpr_pkg;
  // decoded intent of one side for the current cycle
  typedef struct packed {
    logic wr;     // store the write byte
    logic rd;     // capture a read
    logic drive;  // read with output gate open
  } side_req_t;
endpackage

// File: rtl/dpr_side_ctrl.sv
module dpr_side_ctrl
  import dpr_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] POST_ADDR = '1,
  parameter logic [ADDR_W-1:0] ACK_ADDR  = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              rw,
  input  logic              busy_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] mem_q,
  output side_req_t         req,
  output logic              post,
  output logic              ack,
  output logic [DATA_W-1:0] rdata,
  output logic              rdrive
);
  logic drive_q;

  always_comb begin
    req.wr    = !ce_n && !rw && busy_n;
    req.rd    = !ce_n && rw;
    req.drive = !ce_n && rw && !oe_n;
    post      = req.wr && (addr == POST_ADDR);
    ack       = req.drive && busy_n && (addr == ACK_ADDR);
  end

  always_ff @(posedge clk) begin
    if (rst) drive_q <= 1'b0;
    else     drive_q <= req.drive;
  end

  assign rdrive = drive_q;
  assign rdata  = drive_q ? mem_q : '0;
endmodule

// File: rtl/dpr_storage.sv
module dpr_storage #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              a_wr,
  input  logic              a_rd,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [DATA_W-1:0] a_wdata,
  output logic [DATA_W-1:0] a_q,
  input  logic              b_wr,
  input  logic              b_rd,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [DATA_W-1:0] b_wdata,
  output logic [DATA_W-1:0] b_q
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [DATA_W-1:0] mem [DEPTH];

  // side b written first so side a wins on a shared address
  always_ff @(posedge clk) begin
    if (b_wr) mem[b_addr] <= b_wdata;
    if (a_wr) mem[a_addr] <= a_wdata;
    if (a_rd) a_q <= mem[a_addr];
    if (b_rd) b_q <= mem[b_addr];
  end
endmodule

// File: rtl/dpr_doorbell.sv
module dpr_doorbell (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic pending
);
  always_ff @(posedge clk) begin
    if (rst)        pending <= 1'b0;
    else if (set_i) pending <= 1'b1;
    else if (clr_i) pending <= 1'b0;
  end
endmodule

// File: rtl/dpr_mailbox_ram.sv
module dpr_mailbox_ram
  import dpr_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              l_ce_n,
  input  logic              l_oe_n,
  input  logic              l_rw,
  input  logic              l_busy_n,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [DATA_W-1:0] l_wdata,
  output logic [DATA_W-1:0] l_rdata,
  output logic              l_rdrive,
  output logic              l_int_n,
  input  logic              r_ce_n,
  input  logic              r_oe_n,
  input  logic              r_rw,
  input  logic              r_busy_n,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] r_rdata,
  output logic              r_rdrive,
  output logic              r_int_n
);
  localparam logic [ADDR_W-1:0] TO_RIGHT = '1;
  localparam logic [ADDR_W-1:0] TO_LEFT  = TO_RIGHT - 1'b1;

  side_req_t         l_req, r_req;
  logic              l_post, l_ack, r_post, r_ack;
  logic [DATA_W-1:0] l_mem_q, r_mem_q;
  logic              l_pend, r_pend;

  dpr_side_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W),
                  .POST_ADDR(TO_RIGHT), .ACK_ADDR(TO_LEFT)) u_lside (
    .clk(clk), .rst(rst), .ce_n(l_ce_n), .oe_n(l_oe_n), .rw(l_rw),
    .busy_n(l_busy_n), .addr(l_addr), .mem_q(l_mem_q), .req(l_req),
    .post(l_post), .ack(l_ack), .rdata(l_rdata), .rdrive(l_rdrive));

  dpr_side_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W),
                  .POST_ADDR(TO_LEFT), .ACK_ADDR(TO_RIGHT)) u_rside (
    .clk(clk), .rst(rst), .ce_n(r_ce_n), .oe_n(r_oe_n), .rw(r_rw),
    .busy_n(r_busy_n), .addr(r_addr), .mem_q(r_mem_q), .req(r_req),
    .post(r_post), .ack(r_ack), .rdata(r_rdata), .rdrive(r_rdrive));

  dpr_storage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk(clk),
    .a_wr(l_req.wr), .a_rd(l_req.rd), .a_addr(l_addr), .a_wdata(l_wdata), .a_q(l_mem_q),
    .b_wr(r_req.wr), .b_rd(r_req.rd), .b_addr(r_addr), .b_wdata(r_wdata), .b_q(r_mem_q));

  dpr_doorbell u_bell_r (.clk(clk), .rst(rst), .set_i(l_post), .clr_i(r_ack), .pending(r_pend));
  dpr_doorbell u_bell_l (.clk(clk), .rst(rst), .set_i(r_post), .clr_i(l_ack), .pending(l_pend));

  assign l_int_n = !l_pend;
  assign r_int_n = !r_pend;
endmodule

// File: rtl/dpr_mailbox_ram_chk.sv
module dpr_mailbox_ram_chk #(
  parameter int ADDR_W = 11
) (
  input logic              clk,
  input logic              rst,
  input logic              l_ce_n,
  input logic              l_oe_n,
  input logic              l_rw,
  input logic              l_busy_n,
  input logic [ADDR_W-1:0] l_addr,
  input logic              l_rdrive,
  input logic              l_int_n,
  input logic              r_ce_n,
  input logic              r_oe_n,
  input logic              r_rw,
  input logic              r_busy_n,
  input logic [ADDR_W-1:0] r_addr,
  input logic              r_rdrive,
  input logic              r_int_n
);
  localparam logic [ADDR_W-1:0] TOP  = '1;
  localparam logic [ADDR_W-1:0] TOP1 = TOP - 1'b1;

  logic l_set_r, r_clr_r, r_set_l;
  assign l_set_r = !l_ce_n && !l_rw && l_busy_n && (l_addr == TOP);
  assign r_clr_r = !r_ce_n && r_rw && !r_oe_n && r_busy_n && (r_addr == TOP);
  assign r_set_l = !r_ce_n && !r_rw && r_busy_n && (r_addr == TOP1);

  // R2
  deselect_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    l_ce_n |=> !l_rdrive);
  // R4
  gate_closed_chk: assert property (@(posedge clk) disable iff (rst)
    (!r_ce_n && r_rw && r_oe_n) |=> !r_rdrive);
  // R4
  gate_open_chk: assert property (@(posedge clk) disable iff (rst)
    (!l_ce_n && l_rw && !l_oe_n) |=> l_rdrive);
  // R5
  right_set_chk: assert property (@(posedge clk) disable iff (rst)
    l_set_r |=> !r_int_n);
  // R7
  left_set_chk: assert property (@(posedge clk) disable iff (rst)
    r_set_l |=> !l_int_n);
  // R6
  right_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (r_clr_r && !l_set_r) |=> r_int_n);
  // R8
  busy_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    (!l_busy_n && !r_clr_r) |=> $stable(r_int_n));
  // R9
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (l_int_n && r_int_n && !l_rdrive && !r_rdrive));
endmodule

bind dpr_mailbox_ram dpr_mailbox_ram_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst),
  .l_ce_n(l_ce_n), .l_oe_n(l_oe_n), .l_rw(l_rw), .l_busy_n(l_busy_n),
  .l_addr(l_addr), .l_rdrive(l_rdrive), .l_int_n(l_int_n),
  .r_ce_n(r_ce_n), .r_oe_n(r_oe_n), .r_rw(r_rw), .r_busy_n(r_busy_n),
  .r_addr(r_addr), .r_rdrive(r_rdrive), .r_int_n(r_int_n));

// File: tb/tb_dpr_mailbox_ram.sv
`timescale 1ns/1ps
module tb_dpr_mailbox_ram;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic l_ce_n = 1, l_oe_n = 1, l_rw = 1, l_busy_n = 1;
  logic r_ce_n = 1, r_oe_n = 1, r_rw = 1, r_busy_n = 1;
  logic [10:0] l_addr = '0, r_addr = '0;
  logic [7:0]  l_wdata = '0, r_wdata = '0;
  logic [7:0]  l_rdata, r_rdata;
  logic        l_rdrive, r_rdrive, l_int_n, r_int_n;

  int checks = 0, fails = 0, cycles = 0;
  bit done = 0;

  always #4 clk = ~clk;

  dpr_mailbox_ram dut (
    .clk(clk), .rst(rst),
    .l_ce_n(l_ce_n), .l_oe_n(l_oe_n), .l_rw(l_rw), .l_busy_n(l_busy_n),
    .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata), .l_rdrive(l_rdrive), .l_int_n(l_int_n),
    .r_ce_n(r_ce_n), .r_oe_n(r_oe_n), .r_rw(r_rw), .r_busy_n(r_busy_n),
    .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata), .r_rdrive(r_rdrive), .r_int_n(r_int_n));

  // read expectation mode: 0 don't care, 1 not driving, 2 driving given byte
  typedef struct packed {
    logic lce, loe, lrw, lbusy; logic [10:0] la; logic [7:0] lw;
    logic rce, roe, rrw, rbusy; logic [10:0] ra; logic [7:0] rw;
    logic [1:0] lm; logic [7:0] lx; logic [1:0] rm; logic [7:0] rx;
    logic eli, eri; logic [3:0] req;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{0,1,0,1,'h005,'hA5, 1,1,1,1,'h000,'h00, 1,0,1,0, 1,1, 3},  // R3 write
    '{1,1,1,1,'h000,'h00, 0,0,1,1,'h005,'h00, 1,0,2,'hA5, 1,1, 1}, // R1 cross read
    '{0,1,0,1,'h7FF,'h3C, 1,1,1,1,'h000,'h00, 1,0,1,0, 1,0, 5},  // R5 set right
    '{1,1,1,1,'h000,'h00, 0,1,1,1,'h7FF,'h00, 1,0,1,0, 1,0, 4},  // R4 gate closed, R6 no clear
    '{1,1,1,1,'h000,'h00, 0,0,1,0,'h7FF,'h00, 1,0,2,'h3C, 1,0, 8}, // R8 busy blocks clear
    '{1,1,1,1,'h000,'h00, 0,0,1,1,'h7FF,'h00, 1,0,2,'h3C, 1,1, 6}, // R6 clear, R10 message
    '{1,1,1,1,'h000,'h00, 0,1,0,1,'h7FE,'h5A, 1,0,1,0, 0,1, 7},  // R7 set left
    '{0,1,0,0,'h7FF,'h11, 1,1,1,1,'h000,'h00, 1,0,1,0, 0,1, 8},  // R8 busy blocks set
    '{1,1,1,1,'h000,'h00, 0,0,1,1,'h7FF,'h00, 1,0,2,'h3C, 0,1, 3}, // R3 busy write dropped
    '{0,0,1,1,'h7FE,'h00, 1,1,1,1,'h000,'h00, 2,'h5A,1,0, 1,1, 7}, // R7 clear left, R10
    '{0,1,0,1,'h100,'h11, 1,1,1,1,'h000,'h00, 1,0,1,0, 1,1, 3},
    '{0,1,0,1,'h100,'h77, 0,0,1,1,'h100,'h00, 1,0,2,'h11, 1,1, 11}, // R11 old data
    '{1,1,1,1,'h000,'h00, 0,0,1,1,'h100,'h00, 1,0,2,'h77, 1,1, 1},
    '{0,1,0,1,'h7FF,'h99, 0,0,1,1,'h7FF,'h00, 1,0,2,'h3C, 1,0, 12}, // R12 set wins
    '{1,1,1,1,'h000,'h00, 0,0,1,1,'h7FF,'h00, 1,0,2,'h99, 1,1, 10}, // R10
    '{0,1,0,1,'h200,'hC3, 1,1,1,1,'h000,'h00, 1,0,1,0, 1,1, 3},
    '{1,0,0,1,'h200,'hFF, 1,1,1,1,'h000,'h00, 1,0,1,0, 1,1, 2},  // R2 deselected
    '{0,0,1,1,'h200,'h00, 1,1,1,1,'h000,'h00, 2,'hC3,1,0, 1,1, 2},
    '{0,1,0,1,'h300,'hAA, 0,1,0,1,'h300,'hBB, 1,0,1,0, 1,1, 13}, // R13 left wins
    '{1,1,1,1,'h000,'h00, 0,0,1,1,'h300,'h00, 1,0,2,'hAA, 1,1, 13}
  };

  task automatic chk(input bit ok, input int req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL R%0d %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    l_ce_n = 1; l_oe_n = 1; l_rw = 1; l_busy_n = 1; l_addr = '0; l_wdata = '0;
    r_ce_n = 1; r_oe_n = 1; r_rw = 1; r_busy_n = 1; r_addr = '0; r_wdata = '0;
  endtask

  task automatic chk_port(input logic [1:0] m, input logic [7:0] x, input logic drv,
                          input logic [7:0] d, input int req, input string side);
    if (m == 2'd1) chk(!drv && d == 8'h00, req, {side, " idle"}, {7'b0, drv, d}, 16'h0000);
    else if (m == 2'd2) chk(drv && d == x, req, {side, " data"}, {7'b0, drv, d}, {8'h01, x});
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=<5000", cycles);
      finish_run();
    end
  end

  initial begin
    idle();
    rst = 1;
    repeat (2) @(negedge clk);
    // R9 reset state
    chk(l_int_n && r_int_n, 9, "ints after reset", {14'b0, l_int_n, r_int_n}, 16'h0003);
    chk(!l_rdrive && !r_rdrive, 9, "drive after reset", {14'b0, l_rdrive, r_rdrive}, 16'h0000);
    rst = 0;

    for (int i = 0; i < NV; i++) begin
      l_ce_n = VECS[i].lce; l_oe_n = VECS[i].loe; l_rw = VECS[i].lrw; l_busy_n = VECS[i].lbusy;
      l_addr = VECS[i].la; l_wdata = VECS[i].lw;
      r_ce_n = VECS[i].rce; r_oe_n = VECS[i].roe; r_rw = VECS[i].rrw; r_busy_n = VECS[i].rbusy;
      r_addr = VECS[i].ra; r_wdata = VECS[i].rw;
      @(negedge clk);
      chk_port(VECS[i].lm, VECS[i].lx, l_rdrive, l_rdata, VECS[i].req, "left");
      chk_port(VECS[i].rm, VECS[i].rx, r_rdrive, r_rdata, VECS[i].req, "right");
      chk(l_int_n == VECS[i].eli, VECS[i].req, "l_int_n", {15'b0, l_int_n}, {15'b0, VECS[i].eli});
      chk(r_int_n == VECS[i].eri, VECS[i].req, "r_int_n", {15'b0, r_int_n}, {15'b0, VECS[i].eri});
    end

    // R1 bottom and top-region locations through opposite sides
    idle();
    r_ce_n = 0; r_rw = 0; r_addr = 11'h000; r_wdata = 8'h5C;
    @(negedge clk);
    idle();
    l_ce_n = 0; l_oe_n = 0; l_rw = 1; l_addr = 11'h000;
    @(negedge clk);
    chk(l_rdrive && l_rdata == 8'h5C, 1, "left reads addr 0", {7'b0, l_rdrive, l_rdata}, 16'h015C);

    // R9 reset clears a pending doorbell
    idle();
    l_ce_n = 0; l_rw = 0; l_addr = 11'h7FF; l_wdata = 8'h42;
    @(negedge clk);
    idle();
    chk(!r_int_n, 5, "doorbell before reset", {15'b0, r_int_n}, 16'h0000);
    rst = 1;
    r_ce_n = 0; r_oe_n = 0; r_rw = 1; r_addr = 11'h100;
    @(negedge clk);
    chk(r_int_n && l_int_n, 9, "ints after mid-run reset", {14'b0, l_int_n, r_int_n}, 16'h0003);
    chk(!r_rdrive, 9, "drive during reset", {15'b0, r_rdrive}, 16'h0000);
    rst = 0;
    idle();
    @(negedge clk);
    finish_run();
  end
endmodule